// File: doc/BRIEF.md
# Paravirtual I/O Transport Register Block

This block is the device-side control register file of a memory-mapped paravirtual I/O transport. A host driver reaches it over a plain 32-bit register bus with an address, a write strobe, write data and a read strobe. The read data comes back registered, one cycle after the read strobe. Through this bus the driver identifies the device and reads the 64-bit device feature set one 32-bit page at a time. It writes the accepted driver features the same way. It programs a bank of virtual queues through a queue selector, rings a doorbell for a queue, services interrupts and steps the device through its status flags.

On the device side, the block takes the 64-bit feature set offered by the device, a used-ring event pulse and a configuration-change event pulse. It drives out the negotiated driver features, the size, ready bit and three 64-bit ring addresses of every queue, a one-cycle doorbell pulse with the written queue index, an interrupt line and the status flags.

Writing zero to the status register is a software reset. It returns the negotiation and queue state to its reset values.

Top module: `mmio_xport_regs`

## Requirements
- R1: A read strobe returns its data on `bus_rdata` one cycle later, and `bus_rdata` holds that value until the next read. Offset 0x000 reads 0x74726976. Offset 0x004 reads 2. Offset 0x008 reads the 8-bit device type in bits 7:0 (default 0x02). Offset 0x00C reads the vendor ID (default 0x00005A17).
- R2: Offset 0x010 reads device feature bits 31:0 when the last value written to 0x014 was 0, and bits 63:32 when it was 1. Any other selector value reads zero.
- R3: A write to 0x020 stores the data into driver feature bits 31:0 when the last value written to 0x024 was 0, and into bits 63:32 when it was 1. Any other selector value makes the write have no effect.
- R4: Offset 0x030 selects a queue, numbered from 0. For a selected queue i below NQ, offset 0x034 reads QMAX >> i (default 256 >> i). At or beyond NQ it reads zero.
- R5: For the selected queue, a write to 0x038 sets its 16-bit size. Writes to 0x080/0x084, 0x090/0x094 and 0x0A0/0x0A4 set the low/high words of its descriptor, available-ring and used-ring addresses. No other queue's values change.
- R6: Bit 0 of a write to 0x044 sets the ready bit of the selected queue, and a read of 0x044 returns that bit. With the selector at or beyond NQ, 0x044 reads zero and all banked queue writes have no effect.
- R7: A write to 0x050 raises `notify_o` for exactly the following cycle, with `notify_idx_o` equal to the written data.
- R8: A used-ring event sets bit 0 of the interrupt status at 0x060, and a config-change event sets bit 1. `irq_o` is high whenever either bit is set.
- R9: A write to 0x064 clears the interrupt status bits that are 1 in the data. An event arriving in the same cycle as the acknowledge keeps its bit set.
- R10: A nonzero write to 0x070 ORs data bits 0, 1, 2, 3 and 7 into the status flags. Bits 6:4 are dropped. Status flags are never cleared except by a zero write.
- R11: Writing zero to 0x070 clears the status flags, the driver features, every queue ready bit, size and ring address, and the interrupt status. The generation counter and the selectors are kept.
- R12: The value read at 0x0FC starts at 0 and increases by one on every config-change event.
- R13: Unmapped offsets, including 0x100 and above, read zero, and writes to them change no output.
- R14: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | AW | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| dev_features_i | input | 64 | Features offered by the device |
| used_evt_i | input | 1 | Used-ring update event pulse |
| cfg_evt_i | input | 1 | Configuration change event pulse |
| drv_features_o | output | 64 | Features accepted by the driver |
| q_ready_o | output | NQ | Ready bit per queue |
| q_size_o | output | NQ*16 | Size per queue, queue 0 in the low bits |
| q_desc_o | output | NQ*64 | Descriptor table address per queue |
| q_avail_o | output | NQ*64 | Available ring address per queue |
| q_used_o | output | NQ*64 | Used ring address per queue |
| notify_o | output | 1 | One-cycle doorbell pulse |
| notify_idx_o | output | 32 | Queue index of the doorbell |
| irq_o | output | 1 | Interrupt line |
| dev_status_o | output | 8 | Device status flags |

## Verification
The bench sweeps the queue selector past the end of the bank. A design that decoded only the low selector bits would alias queue 4 onto queue 0: the ready read and the maximum size would come back wrong, and stored values would be overwritten. Both feature selectors are swept through 0 to 3. A design that ignored the upper selector bits would return or overwrite a real feature page.

The bench raises a used-ring event in the same cycle as the acknowledge of that bit. A design that gave priority to the clear would lose the event. It also writes only the reserved status bits, which is nonzero but masks to zero. A design that tested the masked value for zero would reset the device at that point.

After a software reset, the bench checks every queue output and the driver features. It also checks that the generation count survived.

// File: rtl/mmio_xport_pkg.sv
package mmio_xport_pkg;

  localparam int DW = 32;

  localparam logic [11:0] OFF_MAGIC    = 12'h000;
  localparam logic [11:0] OFF_VERSION  = 12'h004;
  localparam logic [11:0] OFF_DEVTYPE  = 12'h008;
  localparam logic [11:0] OFF_VENDOR   = 12'h00C;
  localparam logic [11:0] OFF_DFEAT    = 12'h010;
  localparam logic [11:0] OFF_DFEATSEL = 12'h014;
  localparam logic [11:0] OFF_AFEAT    = 12'h020;
  localparam logic [11:0] OFF_AFEATSEL = 12'h024;
  localparam logic [11:0] OFF_QSEL     = 12'h030;
  localparam logic [11:0] OFF_QMAX     = 12'h034;
  localparam logic [11:0] OFF_QSIZE    = 12'h038;
  localparam logic [11:0] OFF_QREADY   = 12'h044;
  localparam logic [11:0] OFF_NOTIFY   = 12'h050;
  localparam logic [11:0] OFF_ISTAT    = 12'h060;
  localparam logic [11:0] OFF_IACK     = 12'h064;
  localparam logic [11:0] OFF_STATUS   = 12'h070;
  localparam logic [11:0] OFF_DESC_LO  = 12'h080;
  localparam logic [11:0] OFF_DESC_HI  = 12'h084;
  localparam logic [11:0] OFF_AVAIL_LO = 12'h090;
  localparam logic [11:0] OFF_AVAIL_HI = 12'h094;
  localparam logic [11:0] OFF_USED_LO  = 12'h0A0;
  localparam logic [11:0] OFF_USED_HI  = 12'h0A4;
  localparam logic [11:0] OFF_GEN      = 12'h0FC;

  localparam logic [31:0] MAGIC_WORD  = 32'h7472_6976;
  localparam logic [31:0] IF_VERSION  = 32'd2;
  localparam logic [7:0]  STATUS_MASK = 8'h8F;

  typedef struct packed {
    logic sel;
    logic size;
    logic ready;
    logic desc_lo;
    logic desc_hi;
    logic avail_lo;
    logic avail_hi;
    logic used_lo;
    logic used_hi;
  } q_wr_t;

endpackage

// File: rtl/xp_features.sv
module xp_features
  import mmio_xport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_devsel,
  input  logic          wr_drvsel,
  input  logic          wr_drvfeat,
  input  logic [DW-1:0] wdata,
  input  logic [63:0]   dev_features_i,
  output logic [DW-1:0] dev_word_o,
  output logic [63:0]   drv_features_o
);

  logic [DW-1:0] devsel_q, devsel_d;
  logic [DW-1:0] drvsel_q, drvsel_d;
  logic [63:0]   drv_q, drv_d;

  always_comb begin
    devsel_d = devsel_q;
    drvsel_d = drvsel_q;
    drv_d    = drv_q;
    if (wr_devsel) devsel_d = wdata;
    if (wr_drvsel) drvsel_d = wdata;
    if (soft_rst) begin
      drv_d = '0;
    end else if (wr_drvfeat) begin
      if (drvsel_q == DW'(0)) drv_d[31:0]  = wdata;
      if (drvsel_q == DW'(1)) drv_d[63:32] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      devsel_q <= '0;
      drvsel_q <= '0;
      drv_q    <= '0;
    end else begin
      devsel_q <= devsel_d;
      drvsel_q <= drvsel_d;
      drv_q    <= drv_d;
    end
  end

  always_comb begin
    if (devsel_q == DW'(0))      dev_word_o = dev_features_i[31:0];
    else if (devsel_q == DW'(1)) dev_word_o = dev_features_i[63:32];
    else                         dev_word_o = '0;
  end

  assign drv_features_o = drv_q;

endmodule

// File: rtl/xp_queue_bank.sv
module xp_queue_bank
  import mmio_xport_pkg::*;
#(
  parameter int NQ   = 4,
  parameter int QW   = 16,
  parameter int QMAX = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  q_wr_t          wr,
  input  logic [DW-1:0]  wdata,
  output logic           sel_valid_o,
  output logic [QW-1:0]  max_o,
  output logic           ready_rd_o,
  output logic [NQ-1:0]  q_ready_o,
  output logic [NQ*QW-1:0] q_size_o,
  output logic [NQ*64-1:0] q_desc_o,
  output logic [NQ*64-1:0] q_avail_o,
  output logic [NQ*64-1:0] q_used_o
);

  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1;

  logic [DW-1:0] sel_q, sel_d;
  logic [IW-1:0] sel_idx;

  always_comb begin
    sel_d = sel_q;
    if (wr.sel) sel_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel_valid_o = (sel_q < DW'(NQ));
  assign sel_idx     = sel_q[IW-1:0];

  for (genvar gi = 0; gi < NQ; gi++) begin : g_q
    logic          hit;
    logic          rdy_q, rdy_d;
    logic [QW-1:0] size_q, size_d;
    logic [63:0]   desc_q, desc_d, avail_q, avail_d, used_q, used_d;

    assign hit = sel_valid_o && (sel_idx == IW'(gi));

    always_comb begin
      rdy_d   = rdy_q;
      size_d  = size_q;
      desc_d  = desc_q;
      avail_d = avail_q;
      used_d  = used_q;
      if (soft_rst) begin
        rdy_d   = 1'b0;
        size_d  = '0;
        desc_d  = '0;
        avail_d = '0;
        used_d  = '0;
      end else if (hit) begin
        if (wr.ready)    rdy_d          = wdata[0];
        if (wr.size)     size_d         = wdata[QW-1:0];
        if (wr.desc_lo)  desc_d[31:0]   = wdata;
        if (wr.desc_hi)  desc_d[63:32]  = wdata;
        if (wr.avail_lo) avail_d[31:0]  = wdata;
        if (wr.avail_hi) avail_d[63:32] = wdata;
        if (wr.used_lo)  used_d[31:0]   = wdata;
        if (wr.used_hi)  used_d[63:32]  = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_q   <= 1'b0;
        size_q  <= '0;
        desc_q  <= '0;
        avail_q <= '0;
        used_q  <= '0;
      end else begin
        rdy_q   <= rdy_d;
        size_q  <= size_d;
        desc_q  <= desc_d;
        avail_q <= avail_d;
        used_q  <= used_d;
      end
    end

    assign q_ready_o[gi]              = rdy_q;
    assign q_size_o[gi*QW +: QW]      = size_q;
    assign q_desc_o[gi*64 +: 64]      = desc_q;
    assign q_avail_o[gi*64 +: 64]     = avail_q;
    assign q_used_o[gi*64 +: 64]      = used_q;
  end

  always_comb begin
    max_o      = '0;
    ready_rd_o = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      if (sel_valid_o && (sel_idx == IW'(i))) begin
        max_o      = QW'(QMAX >> i);
        ready_rd_o = q_ready_o[i];
      end
    end
  end

endmodule

// File: rtl/xp_irq.sv
module xp_irq
  import mmio_xport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          used_evt,
  input  logic          cfg_evt,
  input  logic          wr_ack,
  input  logic [1:0]    ack_mask,
  output logic [1:0]    status_o,
  output logic [DW-1:0] gen_o,
  output logic          irq_o
);

  logic [1:0]    st_q, st_d;
  logic [DW-1:0] gen_q, gen_d;

  always_comb begin
    st_d = st_q;
    if (soft_rst) st_d = '0;
    if (wr_ack)   st_d = st_d & ~ack_mask;
    st_d  = st_d | {cfg_evt, used_evt};
    gen_d = gen_q + DW'(cfg_evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      gen_q <= '0;
    end else begin
      st_q  <= st_d;
      gen_q <= gen_d;
    end
  end

  assign status_o = st_q;
  assign gen_o    = gen_q;
  assign irq_o    = |st_q;

endmodule

// File: rtl/mmio_xport_regs.sv
module mmio_xport_regs
  import mmio_xport_pkg::*;
#(
  parameter int          AW       = 12,
  parameter int          NQ       = 4,
  parameter int          QMAX     = 256,
  parameter logic [7:0]  DEV_TYPE = 8'h02,
  parameter logic [31:0] VENDOR   = 32'h0000_5A17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_rd,
  output logic [31:0]      bus_rdata,
  input  logic [63:0]      dev_features_i,
  input  logic             used_evt_i,
  input  logic             cfg_evt_i,
  output logic [63:0]      drv_features_o,
  output logic [NQ-1:0]    q_ready_o,
  output logic [NQ*16-1:0] q_size_o,
  output logic [NQ*64-1:0] q_desc_o,
  output logic [NQ*64-1:0] q_avail_o,
  output logic [NQ*64-1:0] q_used_o,
  output logic             notify_o,
  output logic [31:0]      notify_idx_o,
  output logic             irq_o,
  output logic [7:0]       dev_status_o
);

  localparam int QW = 16;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  function automatic logic at(input logic [11:0] off);
    return bus_addr == AW'(off);
  endfunction

  logic  wr_status, soft_rst, wr_notify;
  q_wr_t qwr;

  assign wr_status = bus_wr && at(OFF_STATUS);
  assign soft_rst  = wr_status && (bus_wdata == '0);
  assign wr_notify = bus_wr && at(OFF_NOTIFY);

  always_comb begin
    qwr.sel      = bus_wr && at(OFF_QSEL);
    qwr.size     = bus_wr && at(OFF_QSIZE);
    qwr.ready    = bus_wr && at(OFF_QREADY);
    qwr.desc_lo  = bus_wr && at(OFF_DESC_LO);
    qwr.desc_hi  = bus_wr && at(OFF_DESC_HI);
    qwr.avail_lo = bus_wr && at(OFF_AVAIL_LO);
    qwr.avail_hi = bus_wr && at(OFF_AVAIL_HI);
    qwr.used_lo  = bus_wr && at(OFF_USED_LO);
    qwr.used_hi  = bus_wr && at(OFF_USED_HI);
  end

  logic [31:0]   dev_word;
  logic          qsel_valid, q_ready_rd;
  logic [QW-1:0] q_max;
  logic [1:0]    int_status;
  logic [31:0]   cfg_gen;

  xp_features feat_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .soft_rst      (soft_rst),
    .wr_devsel     (bus_wr && at(OFF_DFEATSEL)),
    .wr_drvsel     (bus_wr && at(OFF_AFEATSEL)),
    .wr_drvfeat    (bus_wr && at(OFF_AFEAT)),
    .wdata         (bus_wdata),
    .dev_features_i(dev_features_i),
    .dev_word_o    (dev_word),
    .drv_features_o(drv_features_o)
  );

  xp_queue_bank #(.NQ(NQ), .QW(QW), .QMAX(QMAX)) qbank_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .soft_rst   (soft_rst),
    .wr         (qwr),
    .wdata      (bus_wdata),
    .sel_valid_o(qsel_valid),
    .max_o      (q_max),
    .ready_rd_o (q_ready_rd),
    .q_ready_o  (q_ready_o),
    .q_size_o   (q_size_o),
    .q_desc_o   (q_desc_o),
    .q_avail_o  (q_avail_o),
    .q_used_o   (q_used_o)
  );

  xp_irq irq_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .soft_rst(soft_rst),
    .used_evt(used_evt_i),
    .cfg_evt (cfg_evt_i),
    .wr_ack  (bus_wr && at(OFF_IACK)),
    .ack_mask(bus_wdata[1:0]),
    .status_o(int_status),
    .gen_o   (cfg_gen),
    .irq_o   (irq_o)
  );

  // status flags, doorbell, read data
  logic [7:0]  stat_q, stat_d;
  logic        ntf_q, ntf_d;
  logic [31:0] nidx_q, nidx_d;
  logic [31:0] rdata_q, rdata_d, rd_mux;

  always_comb begin
    rd_mux = '0;
    if      (at(OFF_MAGIC))   rd_mux = MAGIC_WORD;
    else if (at(OFF_VERSION)) rd_mux = IF_VERSION;
    else if (at(OFF_DEVTYPE)) rd_mux = {24'h0, DEV_TYPE};
    else if (at(OFF_VENDOR))  rd_mux = VENDOR;
    else if (at(OFF_DFEAT))   rd_mux = dev_word;
    else if (at(OFF_QMAX))    rd_mux = 32'(q_max);
    else if (at(OFF_QREADY))  rd_mux = {31'h0, q_ready_rd};
    else if (at(OFF_ISTAT))   rd_mux = {30'h0, int_status};
    else if (at(OFF_STATUS))  rd_mux = {24'h0, stat_q};
    else if (at(OFF_GEN))     rd_mux = cfg_gen;
  end

  always_comb begin
    stat_d  = stat_q;
    if (soft_rst)       stat_d = '0;
    else if (wr_status) stat_d = stat_q | (bus_wdata[7:0] & STATUS_MASK);
    ntf_d   = wr_notify;
    nidx_d  = wr_notify ? bus_wdata : nidx_q;
    rdata_d = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stat_q  <= '0;
      ntf_q   <= 1'b0;
      nidx_q  <= '0;
      rdata_q <= '0;
    end else begin
      stat_q  <= stat_d;
      ntf_q   <= ntf_d;
      nidx_q  <= nidx_d;
      rdata_q <= rdata_d;
    end
  end

  assign dev_status_o = stat_q;
  assign notify_o     = ntf_q;
  assign notify_idx_o = nidx_q;
  assign bus_rdata    = rdata_q;

endmodule

module mmio_xport_regs_chk
  import mmio_xport_pkg::*;
#(
  parameter int AW = 12,
  parameter int NQ = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [31:0]   bus_wdata,
  input logic          used_evt_i,
  input logic          cfg_evt_i,
  input logic          notify_o,
  input logic [31:0]   notify_idx_o,
  input logic          irq_o,
  input logic [7:0]    dev_status_o,
  input logic [NQ-1:0] q_ready_o,
  input logic [63:0]   drv_features_o,
  input logic [31:0]   gen_i,
  input logic          qsel_ok_i
);

  // R7
  doorbell_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(OFF_NOTIFY)) |=> (notify_o && notify_idx_o == $past(bus_wdata)));

  // R8
  used_evt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_evt_i |=> irq_o);

  // R12
  gen_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_evt_i |=> (gen_i == $past(gen_i) + 32'd1));

  // R11
  soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(OFF_STATUS) && bus_wdata == 32'h0)
      |=> (dev_status_o == 8'h0 && q_ready_o == '0 && drv_features_o == 64'h0));

  // R10
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(OFF_STATUS) && bus_wdata == 32'h0)
      |=> ((dev_status_o & $past(dev_status_o)) == $past(dev_status_o)));

  // R6
  oob_ready_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !qsel_ok_i && bus_addr == AW'(OFF_QREADY)) |=> $stable(q_ready_o));

endmodule

bind mmio_xport_regs mmio_xport_regs_chk #(.AW(AW), .NQ(NQ)) chk_i (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .used_evt_i    (used_evt_i),
  .cfg_evt_i     (cfg_evt_i),
  .notify_o      (notify_o),
  .notify_idx_o  (notify_idx_o),
  .irq_o         (irq_o),
  .dev_status_o  (dev_status_o),
  .q_ready_o     (q_ready_o),
  .drv_features_o(drv_features_o),
  .gen_i         (cfg_gen),
  .qsel_ok_i     (qsel_valid)
);

// File: tb/mmio_xport_regs_tb_top.sv
`timescale 1ns/1ps
module mmio_xport_regs_tb_top;

  localparam int NQ = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [11:0]      bus_addr;
  logic             bus_wr, bus_rd;
  logic [31:0]      bus_wdata, bus_rdata;
  logic [63:0]      dev_features_i;
  logic             used_evt_i, cfg_evt_i;
  logic [63:0]      drv_features_o;
  logic [NQ-1:0]    q_ready_o;
  logic [NQ*16-1:0] q_size_o;
  logic [NQ*64-1:0] q_desc_o, q_avail_o, q_used_o;
  logic             notify_o, irq_o;
  logic [31:0]      notify_idx_o;
  logic [7:0]       dev_status_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mmio_xport_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dev_features_i(dev_features_i), .used_evt_i(used_evt_i), .cfg_evt_i(cfg_evt_i),
    .drv_features_o(drv_features_o), .q_ready_o(q_ready_o), .q_size_o(q_size_o),
    .q_desc_o(q_desc_o), .q_avail_o(q_avail_o), .q_used_o(q_used_o),
    .notify_o(notify_o), .notify_idx_o(notify_idx_o), .irq_o(irq_o),
    .dev_status_o(dev_status_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic used, input logic cfg);
    @(negedge clk);
    used_evt_i = used; cfg_evt_i = cfg;
    @(negedge clk);
    used_evt_i = 1'b0; cfg_evt_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [15:0] e_size[NQ];
  logic [63:0] e_desc[NQ], e_avail[NQ], e_used[NQ];
  logic        e_rdy[NQ];
  logic [63:0] e_drv;

  task automatic check_queues(input string req);
    for (int i = 0; i < NQ; i++) begin
      chk(req, {63'h0, q_ready_o[i]}, {63'h0, e_rdy[i]});
      chk(req, {48'h0, q_size_o[i*16 +: 16]}, {48'h0, e_size[i]});
      chk(req, q_desc_o[i*64 +: 64], e_desc[i]);
      chk(req, q_avail_o[i*64 +: 64], e_avail[i]);
      chk(req, q_used_o[i*64 +: 64], e_used[i]);
    end
  endtask

  initial begin
    logic [31:0] rv, g0;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    dev_features_i = 64'hA5C3_0F1E_1234_5678; used_evt_i = 1'b0; cfg_evt_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R14 reset state
    chk("R14 irq", {63'h0, irq_o}, 64'h0);
    chk("R14 notify", {63'h0, notify_o}, 64'h0);
    chk("R14 status", {56'h0, dev_status_o}, 64'h0);
    chk("R14 drv", drv_features_o, 64'h0);
    chk("R14 ready", {60'h0, q_ready_o}, 64'h0);
    chk("R14 rdata", {32'h0, bus_rdata}, 64'h0);

    // R1 identification
    rd(12'h000, rv); chk("R1 magic", {32'h0, rv}, 64'h7472_6976);
    rd(12'h004, rv); chk("R1 version", {32'h0, rv}, 64'd2);
    rd(12'h008, rv); chk("R1 type", {32'h0, rv}, 64'h02);
    rd(12'h00C, rv); chk("R1 vendor", {32'h0, rv}, 64'h5A17);
    @(negedge clk); chk("R1 hold", {32'h0, bus_rdata}, 64'h5A17);

    // R2 device feature pages
    for (int s = 0; s < 4; s++) begin
      wr(12'h014, 32'(s));
      rd(12'h010, rv);
      chk("R2 page", {32'h0, rv},
          (s == 0) ? {32'h0, dev_features_i[31:0]} :
          (s == 1) ? {32'h0, dev_features_i[63:32]} : 64'h0);
    end

    // R3 driver feature pages
    e_drv = '0;
    for (int s = 0; s < 4; s++) begin
      wr(12'h024, 32'(s));
      wr(12'h020, 32'h6B00_0000 + 32'(s * 7));
      if (s == 0) e_drv[31:0]  = 32'h6B00_0000 + 32'(s * 7);
      if (s == 1) e_drv[63:32] = 32'h6B00_0000 + 32'(s * 7);
      chk("R3 drv", drv_features_o, e_drv);
    end

    // R4 R5 R6 queue sweep beyond the bank
    for (int i = 0; i < NQ; i++) begin
      e_size[i] = '0; e_desc[i] = '0; e_avail[i] = '0; e_used[i] = '0; e_rdy[i] = 1'b0;
    end
    for (int s = 0; s < 6; s++) begin
      wr(12'h030, 32'(s));
      rd(12'h034, rv);
      chk("R4 qmax", {32'h0, rv}, (s < NQ) ? 64'(256 >> s) : 64'h0);
      wr(12'h038, 32'(s * 3 + 5));
      wr(12'h044, 32'((s % 2) == 0));
      wr(12'h080, 32'hD000_0000 + 32'(s));
      wr(12'h084, 32'hD100_0000 + 32'(s));
      wr(12'h090, 32'hA000_0000 + 32'(s));
      wr(12'h094, 32'hA100_0000 + 32'(s));
      wr(12'h0A0, 32'hB000_0000 + 32'(s));
      wr(12'h0A4, 32'hB100_0000 + 32'(s));
      if (s < NQ) begin
        e_size[s]  = 16'(s * 3 + 5);
        e_rdy[s]   = ((s % 2) == 0);
        e_desc[s]  = {32'hD100_0000 + 32'(s), 32'hD000_0000 + 32'(s)};
        e_avail[s] = {32'hA100_0000 + 32'(s), 32'hA000_0000 + 32'(s)};
        e_used[s]  = {32'hB100_0000 + 32'(s), 32'hB000_0000 + 32'(s)};
      end
      rd(12'h044, rv);
      chk("R6 ready read", {32'h0, rv}, (s < NQ) ? {63'h0, e_rdy[s]} : 64'h0);
      check_queues("R5 R6 bank");
    end

    // R7 doorbell
    wr(12'h050, 32'h3);
    chk("R7 pulse", {63'h0, notify_o}, 64'h1);
    chk("R7 idx", {32'h0, notify_idx_o}, 64'h3);
    @(negedge clk);
    chk("R7 one cycle", {63'h0, notify_o}, 64'h0);

    // R8 R12 R9 interrupts and generation
    rd(12'h0FC, g0);
    chk("R12 start", {32'h0, g0}, 64'h0);
    pulse_evt(1'b1, 1'b0);
    chk("R8 irq used", {63'h0, irq_o}, 64'h1);
    rd(12'h060, rv); chk("R8 stat", {32'h0, rv}, 64'h1);
    pulse_evt(1'b0, 1'b1);
    pulse_evt(1'b0, 1'b1);
    rd(12'h060, rv); chk("R8 stat both", {32'h0, rv}, 64'h3);
    rd(12'h0FC, rv); chk("R12 gen", {32'h0, rv}, 64'h2);
    wr(12'h064, 32'h1);
    rd(12'h060, rv); chk("R9 ack0", {32'h0, rv}, 64'h2);
    chk("R8 irq still", {63'h0, irq_o}, 64'h1);
    wr(12'h064, 32'h2);
    chk("R9 irq clear", {63'h0, irq_o}, 64'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h064; bus_wdata = 32'h1; used_evt_i = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; used_evt_i = 1'b0;
    rd(12'h060, rv); chk("R9 event wins", {32'h0, rv}, 64'h1);
    wr(12'h064, 32'h3);
    rd(12'h060, rv); chk("R9 clear all", {32'h0, rv}, 64'h0);

    // R10 status flags
    wr(12'h070, 32'h1);
    wr(12'h070, 32'h2);
    wr(12'h070, 32'h4);
    chk("R10 or", {56'h0, dev_status_o}, 64'h07);
    wr(12'h070, 32'h70);
    chk("R10 reserved", {56'h0, dev_status_o}, 64'h07);
    chk("R10 no reset", drv_features_o, e_drv);
    wr(12'h070, 32'h88);
    rd(12'h070, rv); chk("R10 read", {32'h0, rv}, 64'h8F);

    // R13 unmapped offsets
    foreach (e_rdy[i]) begin end
    rd(12'h018, rv); chk("R13 rd 018", {32'h0, rv}, 64'h0);
    rd(12'h040, rv); chk("R13 rd 040", {32'h0, rv}, 64'h0);
    rd(12'h100, rv); chk("R13 rd 100", {32'h0, rv}, 64'h0);
    wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h104, 32'h0);
    wr(12'h0A8, 32'hFFFF_FFFF);
    chk("R13 status", {56'h0, dev_status_o}, 64'h8F);
    chk("R13 drv", drv_features_o, e_drv);
    check_queues("R13 queues");

    // R11 software reset
    pulse_evt(1'b1, 1'b0);
    wr(12'h070, 32'h0);
    chk("R11 status", {56'h0, dev_status_o}, 64'h0);
    chk("R11 drv", drv_features_o, 64'h0);
    chk("R11 irq", {63'h0, irq_o}, 64'h0);
    for (int i = 0; i < NQ; i++) begin
      e_size[i] = '0; e_desc[i] = '0; e_avail[i] = '0; e_used[i] = '0; e_rdy[i] = 1'b0;
    end
    check_queues("R11 queues");
    rd(12'h0FC, rv); chk("R11 gen kept", {32'h0, rv}, 64'h2);
    rd(12'h010, rv); chk("R11 devsel kept", {32'h0, rv}, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule